// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-ported static memory with a synchronous, flow-through burst interface. Address, chip selects, strobes, advance, write controls and write data are all captured on the rising clock edge. Read data comes straight out of the array from the captured address during the same cycle, so it appears after that edge without a further pipeline stage. An asynchronous output enable gates the read data.

A cycle begins when either of two active-low address strobes captures a new address and the chip-select state. One strobe is meant for a processor and the other for a memory controller. After that, an active-low advance input steps a 2-bit burst counter that replaces the two low address bits. The counter order is linear or interleaved, chosen by a static mode input, and it always wraps inside the aligned 4-word block. Writes are done per byte lane: per-lane enables count only when a byte-write qualifier is low, and a global write input forces every lane.

The control is a three-state machine.
- **ST_DESEL**: no access.
- **ST_READ**: a read cycle.
- **ST_WRITE**: a write cycle.

The machine has five named transitions.
- **LOAD_RD**: a strobe with the device selected starts a read.
- **LOAD_WR**: the controller strobe with the device selected and at least one lane enabled starts a write.
- **DESELECT**: a strobe with the device not selected goes to ST_DESEL.
- **ADVANCE**: no strobe and advance low steps the counter. The cycle is a write if lanes are enabled, otherwise a read.
- **WAIT**: no strobe and advance high holds the address. The same read/write choice applies.

ST_DESEL stays in ST_DESEL unless a strobe arrives.

Top module: `sync_burst_sram`

## Requirements
- R1: Write data and write controls are captured on the same rising edge that sets the cycle's address. The written lanes are committed at the next rising edge, so a read cycle that directly follows returns the new data.
- R2: At a rising edge, either address strobe that is low and effective loads `addr` as the burst base and clears the burst counter to 0. The word accessed in that cycle is `addr`.
- R3: With no effective strobe in an active burst, `adv_n` low steps the burst counter by one. `adv_n` high holds the current word (wait cycle).
- R4: When `burst_il`=0 the low address bits are (base[1:0] + count) mod 4. When `burst_il`=1 they are base[1:0] XOR count. The upper address bits never change during a burst.
- R5: When `gwe_n`=1 and `bwe_n`=0, lane i (bits i*LANE_W up to i*LANE_W+LANE_W-1) is written exactly when `byte_we_n[i]`=0. When `gwe_n`=1 and `bwe_n`=1, no lane is written and the cycle is a read.
- R6: `gwe_n`=0 writes all lanes, whatever `bwe_n` and `byte_we_n` are.
- R7: `q_en` is 1 only during a read cycle with `oe_n`=0, and it follows `oe_n` without a clock. When `q_en`=0, `q` is all zeros. In a write cycle, `q_en` is 0.
- R8: The device is selected only when `ce_n`=0, `ce2`=1 and `ce3_n`=0 at the strobe. A strobe with the device not selected enters ST_DESEL. There, no lane is written and `q_en` stays 0 until a later strobe selects the device.
- R9: A processor strobe (`ads_proc_n`=0) is ignored while `ce_n`=1. The cycle then continues the current burst as if no strobe had arrived.
- R10: A cycle started by the processor strobe alone is always a read, even with write controls active. If both strobes are low together, the controller strobe rules and the write controls apply.
- R11: After reset the machine is in ST_DESEL, `q_en`=0 and no lane is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address, captured by a strobe |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Depth-expansion select, active high |
| ce3_n | input | 1 | Depth-expansion select, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| byte_we_n | input | LANES | Per-lane write enables, active low |
| gwe_n | input | 1 | Global write, active low |
| burst_il | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_en | output | 1 | Drive enable for the data pads |

## Verification
The counter assertions take the burst order input as static around each edge and every control input as a defined 0 or 1 at each rising edge. The write-mask assertions assume the write-data and control inputs are never unknown while a strobe or continue cycle is decoded. The stimulus changes every input one nanosecond after the falling edge, so all inputs are settled long before each rising edge. It changes `burst_il` only between whole bursts. Every read it issues targets a word that an earlier write has already defined, so the array never returns an unknown value.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sbs_state_t;

    // Low two address bits for a given burst step.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ step;
        else            r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/sbs_write_dec.sv
`timescale 1ns/1ps
module sbs_write_dec #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] byte_we_n,
    input  logic             bwe_n,
    input  logic             gwe_n,
    output logic [LANES-1:0] lane_mask
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                if (!gwe_n)      lane_mask[g] = 1'b1;
                else if (!bwe_n) lane_mask[g] = ~byte_we_n[g];
                else             lane_mask[g] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              interleave,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= 2'd0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    assign eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, interleave)};

    // A load restarts the burst at the captured address.
    assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == 2'd0) && (base_q == $past(addr_in)));

    // Advance moves the counter by one and wraps.
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(base_q));

    // Without load or step the word is held.
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_mask[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end

            assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
        end
    endgenerate

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic                    gwe_n,
    input  logic                    burst_il,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_en
);

    localparam int DW = LANES * LANE_W;

    sbs_state_t        state_q, state_d;
    logic [LANES-1:0]  lane_mask;
    logic [LANES-1:0]  wr_mask_q, wr_mask_d;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rd_data;
    logic [ADDR_W-1:0] eff_addr;
    logic              ctrl_hit, proc_hit, strobe, selected;
    logic              load, step;

    assign ctrl_hit = !ads_ctrl_n;
    assign proc_hit = !ads_proc_n && !ce_n;
    assign strobe   = ctrl_hit || proc_hit;
    assign selected = !ce_n && ce2 && !ce3_n;

    sbs_write_dec #(.LANES(LANES)) u_dec (
        .byte_we_n (byte_we_n),
        .bwe_n     (bwe_n),
        .gwe_n     (gwe_n),
        .lane_mask (lane_mask)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .addr_in    (addr),
        .interleave (burst_il),
        .eff_addr   (eff_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .wr_mask (wr_mask_q),
        .wr_addr (eff_addr),
        .wr_data (wdata_q),
        .rd_addr (eff_addr),
        .rd_data (rd_data)
    );

    // Next-state decode: LOAD_RD, LOAD_WR, DESELECT, ADVANCE, WAIT.
    always_comb begin
        state_d   = state_q;
        wr_mask_d = '0;
        load      = 1'b0;
        step      = 1'b0;
        if (strobe) begin
            if (selected) begin
                load = 1'b1;
                if (ctrl_hit && |lane_mask) begin
                    state_d   = ST_WRITE;
                    wr_mask_d = lane_mask;
                end else begin
                    state_d   = ST_READ;
                end
            end else begin
                state_d = ST_DESEL;
            end
        end else begin
            unique case (state_q)
                ST_DESEL: state_d = ST_DESEL;
                ST_READ, ST_WRITE: begin
                    step = !adv_n;
                    if (|lane_mask) begin
                        state_d   = ST_WRITE;
                        wr_mask_d = lane_mask;
                    end else begin
                        state_d   = ST_READ;
                    end
                end
                default: state_d = ST_DESEL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_DESEL;
            wr_mask_q <= '0;
            wdata_q   <= '0;
        end else begin
            state_q   <= state_d;
            wr_mask_q <= wr_mask_d;
            wdata_q   <= wdata;
        end
    end

    // Output process: flow-through data gated by the asynchronous enable.
    always_comb begin
        q_en = (state_q == ST_READ) && !oe_n;
        q    = q_en ? rd_data : '0;
    end

    assert_desel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !selected) |=> (state_q == ST_DESEL) && (wr_mask_q == '0));

    assert_proc_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && ads_ctrl_n && selected) |=> (state_q == ST_READ));

    assert_gw_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gwe_n && ctrl_hit && selected) |=> (wr_mask_q == {LANES{1'b1}}));

    assert_bwe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gwe_n && bwe_n) |=> (wr_mask_q == '0));

    assert_no_drive_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_q != '0) |-> !q_en);

endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;

    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam logic [2:0] SEL = 3'b010;   // {ce_n, ce2, ce3_n}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic ce_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic bwe_n = 1'b1, gwe_n = 1'b1, burst_il = 1'b0, oe_n = 1'b1;
    logic [LN-1:0] byte_we_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] q;
    logic q_en;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
        .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2),
        .ce3_n(ce3_n), .bwe_n(bwe_n), .byte_we_n(byte_we_n), .gwe_n(gwe_n),
        .burst_il(burst_il), .oe_n(oe_n), .wdata(wdata), .q(q), .q_en(q_en)
    );

    // Reference model state.
    logic [DW-1:0] ref_mem [1<<AW];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;

    // Scoreboard queues.
    logic          exp_en [$];
    logic [DW-1:0] exp_d  [$];
    string         exp_tag[$];

    task automatic drv(input string tag, input logic ap, input logic ac,
                       input logic adv, input logic [2:0] ce,
                       input logic [LN-1:0] bw, input logic bwe, input logic gw,
                       input logic oe, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        logic [LN-1:0] lanes;
        logic c_hit, p_hit, sel, wr, en;
        logic [AW-1:0] eff;
        logic [1:0] lo;
        @(negedge clk);
        #1;
        ads_proc_n = ap; ads_ctrl_n = ac; adv_n = adv;
        {ce_n, ce2, ce3_n} = ce;
        byte_we_n = bw; bwe_n = bwe; gwe_n = gw; oe_n = oe;
        addr = a; wdata = wd;
        lanes = !gw ? '1 : (!bwe ? ~bw : '0);
        c_hit = !ac;
        p_hit = !ap && !ce[2];
        sel = (ce == SEL);
        wr = 1'b0;
        if (c_hit || p_hit) begin
            if (sel) begin
                m_act = 1'b1; m_base = a; m_cnt = 2'd0;
                wr = c_hit && (lanes != '0);
            end else begin
                m_act = 1'b0;
            end
        end else if (m_act) begin
            if (!adv) m_cnt = m_cnt + 2'd1;
            wr = (lanes != '0);
        end
        lo  = burst_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        eff = {m_base[AW-1:2], lo};
        if (m_act && wr) begin
            for (int i = 0; i < LN; i++)
                if (lanes[i]) ref_mem[eff][i*LW +: LW] = wd[i*LW +: LW];
        end
        en = m_act && !wr && !oe;
        exp_en.push_back(en);
        exp_d.push_back(en ? ref_mem[eff] : '0);
        exp_tag.push_back(tag);
    endtask

    // Monitor: each cycle's result is seen at the falling edge after it starts.
    always @(negedge clk) begin
        if (rst_n && exp_en.size() > 0) begin
            logic e; logic [DW-1:0] d; string t;
            e = exp_en.pop_front();
            d = exp_d.pop_front();
            t = exp_tag.pop_front();
            total++;
            if (q_en !== e || q !== d) begin
                bad++;
                $display("FAIL %s: q_en=%0b q=%h expected q_en=%0b q=%h", t, q_en, q, e, d);
            end
        end
    end

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [LN-1:0] NB = '1;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (q_en !== 1'b0 || q !== '0) begin
            bad++;
            $display("FAIL R11 reset: q_en=%0b q=%h expected q_en=0 q=0", q_en, q);
        end
        #1 rst_n = 1'b1;

        // R6/R3 linear burst writes by global write, block 0x10.
        drv("R6 gw load", 1, 0, 1, SEL, NB, 1, 0, 1, 8'h10, 36'h1_0101_0101);
        drv("R6 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'h1_1111_1111);
        drv("R6 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'h2_2222_2222);
        drv("R6 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'h3_3333_3333);
        // Block 0x20.
        drv("R6 gw load", 1, 0, 1, SEL, NB, 1, 0, 1, 8'h20, 36'hA_0000_000A);
        drv("R3 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'hA_1111_111B);
        drv("R3 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'hA_2222_222C);
        drv("R3 gw adv", 1, 1, 0, SEL, NB, 1, 0, 1, 8'h00, 36'hA_3333_333D);

        // R4 linear read from 0x12 wraps 12,13,10,11; R1 read follows writes.
        drv("R1 R2 linear load", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h12, '0);
        drv("R4 linear adv", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R4 linear wrap", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R4 linear adv", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R3 wait hold", 1, 1, 1, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R7 oe high", 1, 1, 0, SEL, NB, 1, 1, 1, 8'h00, '0);
        drv("R3 wrap back", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);

        // R4 interleaved read from 0x21 via processor strobe: 21,20,23,22.
        @(negedge clk); #1 burst_il = 1'b1;
        drv("R4 il load", 0, 1, 1, SEL, NB, 1, 1, 0, 8'h21, '0);
        drv("R4 il adv", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R4 il adv", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);
        drv("R4 il adv", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);

        // R5 byte write lanes 0 and 2, then read.
        drv("R5 byte wr", 1, 0, 1, SEL, 4'b1010, 0, 1, 0, 8'h13, 36'h5_5555_5555);
        drv("R5 byte rd", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h13, '0);
        // R5 enables without qualifier: read, no write.
        drv("R5 bwe high", 1, 0, 1, SEL, 4'b0000, 1, 1, 0, 8'h12, 36'h7_7777_7777);
        drv("R5 unchanged", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h12, '0);
        // R6 global write overrides disabled lanes.
        drv("R6 gw override", 1, 0, 1, SEL, NB, 1, 0, 0, 8'h11, 36'h9_8765_4321);
        drv("R6 gw read", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h11, '0);

        // R10 processor strobe with global write active stays a read.
        drv("R10 proc read", 0, 1, 1, SEL, NB, 1, 0, 0, 8'h10, 36'hF_0F0F_0F0F);
        drv("R10 proc no write", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h10, '0);
        // R10 both strobes: controller wins, write happens.
        drv("R10 both write", 0, 0, 1, SEL, NB, 1, 0, 0, 8'h10, 36'hE_1E1E_1E1E);
        drv("R10 both read", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h10, '0);

        // R9 processor strobe ignored while ce_n high: burst continues 22 -> 23.
        drv("R9 start", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h22, '0);
        drv("R9 ignored", 0, 1, 0, 3'b110, NB, 1, 1, 0, 8'h20, '0);
        drv("R9 continue", 1, 1, 0, SEL, NB, 1, 1, 0, 8'h00, '0);

        // R8 deselect by ce2 low, write attempts ignored while idle.
        drv("R8 desel ce2", 1, 0, 1, 3'b000, NB, 1, 1, 0, 8'h10, '0);
        drv("R8 idle no wr", 1, 1, 0, SEL, NB, 1, 0, 0, 8'h00, 36'h0_DEAD_BEEF);
        drv("R8 check mem", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h10, '0);
        drv("R8 desel ce3", 1, 0, 1, 3'b011, NB, 1, 1, 0, 8'h11, '0);
        drv("R8 check 11", 1, 0, 1, SEL, NB, 1, 1, 0, 8'h11, '0);
        drv("R7 oe off", 1, 1, 1, SEL, NB, 1, 1, 1, 8'h00, '0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule